// File: doc/BRIEF.md
# 16-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small 16-bit microcontroller datapath. It is purely combinational. Each operation takes a source operand, a destination operand, an operation code, a byte/word select and the current carry. It returns a result, a write-enable for the destination, and next values for the overflow (V), negative (N), zero (Z) and carry (C) flags. Each flag comes with its own update mask, which tells the surrounding core whether the status register takes the new value.

The block covers binary add and subtract, with and without carry, and a compare that does not write. It also has packed-BCD decimal add, the bitwise operations (AND, bit test, bit clear, bit set, XOR), arithmetic shift right, rotate right through carry, byte swap and sign extension. Subtraction is built as an addition of the inverted source with a carry-in of 1, or of the carry flag.

In byte mode only the low eight bits take part, and both the sign and the carry-out are taken at bit 7. The block has no clocked state, so the opcode decode stands in for the state machine of a sequential design. Every opcode value is named in R1, and each opcode selects one fixed path through the datapath.

Top module: `alu16_flags`

## Requirements
- R1: The 4-bit `op_i` is decoded as follows: 0 ADD, 1 ADDC, 2 SUB, 3 SUBC, 4 CMP, 5 DADD, 6 AND, 7 BIT, 8 BIC, 9 BIS, 10 XOR, 11 RRA, 12 RRC, 13 SWPB, 14 SXT. Code 15 gives a result of 0, deasserts `we_o`, and clears every flag value and every update mask.
- R2: ADD computes src+dst and ignores `c_i`; ADDC computes src+dst+`c_i`. C is the carry out of the MSB. N is the result MSB and Z is set when the result is zero. V is set when both operands have the same sign and the result sign differs from it. All four update masks are set.
- R3: SUB computes dst+~src+1 and SUBC computes dst+~src+`c_i`. C is the carry out of that addition. V is set when the operand signs differ and the result sign differs from the sign of dst. N and Z follow R2 and all four masks are set. CMP behaves as SUB but deasserts `we_o`.
- R4: When `byte_i`=1, only bits 7:0 of the operands are used. The sign and the carry-out are taken at bit 7, and `res_o[15:8]` is 0. SWPB and SXT ignore `byte_i` and always work on the full word.
- R5: DADD adds src, dst and `c_i` as packed BCD digits (4 digits for a word, 2 for a byte). C is the decimal carry out of the top digit, N is the result MSB, Z is set on a zero result and V is 0. All masks are set.
- R6: AND and BIT compute src&dst. They give V=0, N=MSB, Z on a zero result and C=not Z, and all masks are set. BIT deasserts `we_o`.
- R7: BIC computes ~src&dst and BIS computes src|dst. Both write the result, and all four update masks are clear.
- R8: XOR computes src^dst. V is set when both operand MSBs are 1, N and Z follow the result, C=not Z, and all masks are set.
- R9: RRA shifts dst right by one bit and keeps the MSB. RRC shifts dst right by one bit and puts `c_i` into the MSB. Both set C to the shifted-out LSB and V to 0, with N and Z from the result and all masks set.
- R10: SWPB exchanges the two bytes of dst, writes the result and clears all update masks.
- R11: SXT copies bit 7 of dst into bits 15:8. It gives V=0, N=bit 15, Z on a zero result and C=not Z, and all masks are set.
- R12: A flag value output is 0 whenever its update mask is clear, and `we_o` is 1 for every defined opcode except CMP and BIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| op_i | input | 4 | Operation code (R1) |
| byte_i | input | 1 | 1 selects byte operation |
| c_i | input | 1 | Current carry flag |
| res_o | output | 16 | Operation result |
| we_o | output | 1 | Destination write-enable |
| v_o | output | 1 | Next overflow flag |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| upd_v_o | output | 1 | Overflow flag update mask |
| upd_n_o | output | 1 | Negative flag update mask |
| upd_z_o | output | 1 | Zero flag update mask |
| upd_c_o | output | 1 | Carry flag update mask |

## Verification
Every result is combinational, so the result, the write-enable, the flag values and the masks all settle in the same cycle in which the inputs change, with no register in between. The bench applies each vector just after a falling clock edge. It samples every output 2 ns later, well before the next rising edge. A single comparison of result, write-enable, flags and masks therefore checks one operation with no cycle offset to track.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,
        OP_DADD = 4'd5,
        OP_AND  = 4'd6,
        OP_BIT  = 4'd7,
        OP_BIC  = 4'd8,
        OP_BIS  = 4'd9,
        OP_XOR  = 4'd10,
        OP_RRA  = 4'd11,
        OP_RRC  = 4'd12,
        OP_SWPB = 4'd13,
        OP_SXT  = 4'd14,
        OP_NONE = 4'd15
    } alu_op_e;

endpackage

// File: rtl/alu16_binadd.sv
// Binary adder with carry and overflow taken at byte or word MSB.
module alu16_binadd #(
    parameter int W  = 16,
    parameter int HW = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W:0]  full_sum;
    logic [HW:0] half_sum;
    logic        a_msb, b_msb, s_msb;

    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        half_sum = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
        if (byte_i) begin
            sum_o  = {{(W-HW){1'b0}}, half_sum[HW-1:0]};
            cout_o = half_sum[HW];
            a_msb  = a_i[HW-1];
            b_msb  = b_i[HW-1];
            s_msb  = half_sum[HW-1];
        end else begin
            sum_o  = full_sum[W-1:0];
            cout_o = full_sum[W];
            a_msb  = a_i[W-1];
            b_msb  = b_i[W-1];
            s_msb  = full_sum[W-1];
        end
        ovf_o = (a_msb == b_msb) && (s_msb != b_msb);
    end
endmodule

// File: rtl/alu16_bcdadd.sv
// Packed BCD adder, one generated stage per decimal digit.
module alu16_bcdadd #(
    parameter int W  = 16,
    parameter int HW = 8,
    parameter int DW = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int ND  = W / DW;
    localparam int NDH = HW / DW;
    localparam logic [DW:0] MAX_DIGIT = (DW+1)'(9);
    localparam logic [DW:0] RADIX     = (DW+1)'(10);

    logic [ND:0]   carry;
    logic [W-1:0]  digits;

    assign carry[0] = cin_i;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        logic [DW:0] raw;
        logic [DW:0] adj;
        always_comb begin
            raw = {1'b0, a_i[g*DW +: DW]} + {1'b0, b_i[g*DW +: DW]} + {{DW{1'b0}}, carry[g]};
            if (raw > MAX_DIGIT) begin
                adj          = raw - RADIX;
                carry[g+1]   = 1'b1;
            end else begin
                adj          = raw;
                carry[g+1]   = 1'b0;
            end
            digits[g*DW +: DW] = adj[DW-1:0];
        end

        // R5: valid BCD inputs give a valid BCD output digit
        always_comb begin
            if (!$isunknown({a_i, b_i, cin_i}) &&
                ({1'b0, a_i[g*DW +: DW]} <= MAX_DIGIT) &&
                ({1'b0, b_i[g*DW +: DW]} <= MAX_DIGIT)) begin
                p_digit_valid_r5: assert ({1'b0, digits[g*DW +: DW]} <= MAX_DIGIT)
                    else $error("digit %0d out of BCD range", g);
            end
        end
    end

    always_comb begin
        if (byte_i) begin
            sum_o  = {{(W-HW){1'b0}}, digits[HW-1:0]};
            cout_o = carry[NDH];
        end else begin
            sum_o  = digits;
            cout_o = carry[ND];
        end
    end
endmodule

// File: rtl/alu16_bitops.sv
// Bitwise, shift, swap and extend operations.
module alu16_bitops
    import alu16_pkg::*;
#(
    parameter int W  = 16,
    parameter int HW = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] res_o,
    output logic         shout_o
);
    logic [W-1:0] raw;

    always_comb begin
        raw = '0;
        unique case (op_i)
            OP_AND, OP_BIT: raw = src_i & dst_i;
            OP_BIC:         raw = ~src_i & dst_i;
            OP_BIS:         raw = src_i | dst_i;
            OP_XOR:         raw = src_i ^ dst_i;
            OP_RRA:         raw = byte_i ? {{(W-HW){1'b0}}, dst_i[HW-1], dst_i[HW-1:1]}
                                         : {dst_i[W-1], dst_i[W-1:1]};
            OP_RRC:         raw = byte_i ? {{(W-HW){1'b0}}, cin_i, dst_i[HW-1:1]}
                                         : {cin_i, dst_i[W-1:1]};
            OP_SWPB:        raw = {dst_i[HW-1:0], dst_i[W-1:HW]};
            OP_SXT:         raw = {{(W-HW){dst_i[HW-1]}}, dst_i[HW-1:0]};
            default:        raw = '0;
        endcase
        res_o   = byte_i ? {{(W-HW){1'b0}}, raw[HW-1:0]} : raw;
        shout_o = dst_i[0];
    end
endmodule

// File: rtl/alu16_flags.sv
// Top: operation decode, result select and per-operation flag matrix.
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DIGIT_W = 4
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [3:0]        op_i,
    input  logic              byte_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              we_o,
    output logic              v_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              upd_v_o,
    output logic              upd_n_o,
    output logic              upd_z_o,
    output logic              upd_c_o
);
    localparam int HALF_W = DATA_W / 2;

    alu_op_e           op;
    logic              eff_byte;
    logic [DATA_W-1:0] add_a;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum, bcd_sum, bit_res;
    logic              add_cout, add_ovf, bcd_cout, bit_shout;
    logic [DATA_W-1:0] res;
    logic              v_raw, c_raw, msb, zero;
    logic [3:0]        mask;

    assign op       = alu_op_e'(op_i);
    assign eff_byte = byte_i && (op != OP_SWPB) && (op != OP_SXT);

    always_comb begin
        add_a   = src_i;
        add_cin = 1'b0;
        unique case (op)
            OP_ADDC:        add_cin = c_i;
            OP_SUB, OP_CMP: begin add_a = ~src_i; add_cin = 1'b1; end
            OP_SUBC:        begin add_a = ~src_i; add_cin = c_i;  end
            default:        add_cin = (op == OP_DADD) ? c_i : 1'b0;
        endcase
    end

    alu16_binadd #(.W(DATA_W), .HW(HALF_W)) u_binadd (
        .a_i(add_a), .b_i(dst_i), .cin_i(add_cin), .byte_i(eff_byte),
        .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    alu16_bcdadd #(.W(DATA_W), .HW(HALF_W), .DW(DIGIT_W)) u_bcdadd (
        .a_i(src_i), .b_i(dst_i), .cin_i(c_i), .byte_i(eff_byte),
        .sum_o(bcd_sum), .cout_o(bcd_cout)
    );

    alu16_bitops #(.W(DATA_W), .HW(HALF_W)) u_bitops (
        .op_i(op), .src_i(src_i), .dst_i(dst_i), .cin_i(c_i), .byte_i(eff_byte),
        .res_o(bit_res), .shout_o(bit_shout)
    );

    always_comb begin
        res   = '0;
        v_raw = 1'b0;
        c_raw = 1'b0;
        mask  = 4'b1111;
        we_o  = 1'b1;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                res   = add_sum;
                v_raw = add_ovf;
                c_raw = add_cout;
                we_o  = (op != OP_CMP);
            end
            OP_DADD: begin
                res   = bcd_sum;
                c_raw = bcd_cout;
            end
            OP_AND, OP_BIT, OP_SXT: begin
                res   = bit_res;
                c_raw = (bit_res != '0);
                we_o  = (op != OP_BIT);
            end
            OP_XOR: begin
                res   = bit_res;
                v_raw = eff_byte ? (src_i[HALF_W-1] & dst_i[HALF_W-1])
                                 : (src_i[DATA_W-1] & dst_i[DATA_W-1]);
                c_raw = (bit_res != '0);
            end
            OP_RRA, OP_RRC: begin
                res   = bit_res;
                c_raw = bit_shout;
            end
            OP_BIC, OP_BIS, OP_SWPB: begin
                res  = bit_res;
                mask = 4'b0000;
            end
            default: begin
                mask = 4'b0000;
                we_o = 1'b0;
            end
        endcase
        msb  = eff_byte ? res[HALF_W-1] : res[DATA_W-1];
        zero = (res == '0);
        res_o   = res;
        upd_v_o = mask[3];
        upd_n_o = mask[2];
        upd_z_o = mask[1];
        upd_c_o = mask[0];
        v_o = mask[3] & v_raw;
        n_o = mask[2] & msb;
        z_o = mask[1] & zero;
        c_o = mask[0] & c_raw;
    end

    always_comb begin
        if (!$isunknown({src_i, dst_i, op_i, byte_i, c_i})) begin
            // R6 / R11: logical results never report overflow
            p_logic_v_clear_r6: assert (!((op == OP_AND || op == OP_BIT || op == OP_SXT) && v_o))
                else $error("overflow set on logical op");
            // R8: carry is the inverse of zero on logical results
            p_c_not_z_r8: assert (!(op == OP_AND || op == OP_BIT || op == OP_XOR || op == OP_SXT)
                                  || (c_o == !z_o))
                else $error("carry not inverse of zero");
            // R4: byte results keep the high byte clear
            p_high_clear_r4: assert (!(eff_byte) || (res_o[DATA_W-1:HALF_W] == '0))
                else $error("high byte set in byte mode");
            // R7 / R10: quiet operations request no flag update
            p_quiet_r7: assert (!(op == OP_BIC || op == OP_BIS || op == OP_SWPB)
                                || ({upd_v_o, upd_n_o, upd_z_o, upd_c_o} == 4'b0000))
                else $error("flag update on quiet op");
            // R12: a flag value is zero while its mask is clear
            p_gate_r12: assert ((upd_v_o || !v_o) && (upd_n_o || !n_o) &&
                                (upd_z_o || !z_o) && (upd_c_o || !c_o))
                else $error("flag value without update mask");
            // R2: zero flag agrees with the result port
            p_zero_r2: assert (!upd_z_o || (z_o == (res_o == '0)))
                else $error("zero flag disagrees with result");
        end
    end
endmodule

// File: tb/test_alu16_flags.sv
module test_alu16_flags;

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  op;
        logic        byt;
        logic        cin;
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] res;
        logic        we;
        logic [3:0]  flg;   // {V,N,Z,C}
        logic [3:0]  msk;   // {V,N,Z,C}
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  4'd0,  1'b0, 1'b1, 16'h1234, 16'h0001, 16'h1235, 1'b1, 4'b0000, 4'b1111}, // R2 add, carry in ignored
        '{8'd2,  4'd0,  1'b0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 4'b1100, 4'b1111}, // R2 overflow
        '{8'd2,  4'd0,  1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'b0011, 4'b1111}, // R2 carry and zero
        '{8'd4,  4'd1,  1'b1, 1'b1, 16'h00FF, 16'h1201, 16'h0001, 1'b1, 4'b0001, 4'b1111}, // R4 byte addc carry at bit 7
        '{8'd4,  4'd0,  1'b1, 1'b0, 16'h0040, 16'h0040, 16'h0080, 1'b1, 4'b1100, 4'b1111}, // R4 byte overflow
        '{8'd3,  4'd2,  1'b0, 1'b0, 16'h0003, 16'h0005, 16'h0002, 1'b1, 4'b0001, 4'b1111}, // R3 sub no borrow
        '{8'd3,  4'd2,  1'b0, 1'b1, 16'h0005, 16'h0003, 16'hFFFE, 1'b1, 4'b0100, 4'b1111}, // R3 sub borrow
        '{8'd3,  4'd2,  1'b0, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 1'b1, 4'b1001, 4'b1111}, // R3 sub overflow
        '{8'd3,  4'd3,  1'b0, 1'b0, 16'h0003, 16'h0005, 16'h0001, 1'b1, 4'b0001, 4'b1111}, // R3 subc carry clear
        '{8'd3,  4'd4,  1'b0, 1'b0, 16'h4444, 16'h4444, 16'h0000, 1'b0, 4'b0011, 4'b1111}, // R3 cmp equal, no write
        '{8'd5,  4'd5,  1'b0, 1'b0, 16'h0199, 16'h0001, 16'h0200, 1'b1, 4'b0000, 4'b1111}, // R5 decimal ripple
        '{8'd5,  4'd5,  1'b0, 1'b1, 16'h9999, 16'h0000, 16'h0000, 1'b1, 4'b0011, 4'b1111}, // R5 decimal carry out
        '{8'd5,  4'd5,  1'b1, 1'b0, 16'h0045, 16'h0055, 16'h0000, 1'b1, 4'b0011, 4'b1111}, // R5 byte decimal carry
        '{8'd5,  4'd5,  1'b0, 1'b0, 16'h5000, 16'h3000, 16'h8000, 1'b1, 4'b0100, 4'b1111}, // R5 decimal negative
        '{8'd6,  4'd6,  1'b0, 1'b1, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b1, 4'b0001, 4'b1111}, // R6 and
        '{8'd6,  4'd6,  1'b0, 1'b1, 16'hFF00, 16'h00FF, 16'h0000, 1'b1, 4'b0010, 4'b1111}, // R6 and zero
        '{8'd6,  4'd7,  1'b1, 1'b0, 16'h0080, 16'h00FF, 16'h0080, 1'b0, 4'b0101, 4'b1111}, // R6 byte bit test
        '{8'd7,  4'd8,  1'b0, 1'b1, 16'h00FF, 16'h1234, 16'h1200, 1'b1, 4'b0000, 4'b0000}, // R7 bic
        '{8'd7,  4'd9,  1'b1, 1'b1, 16'h0001, 16'hFF80, 16'h0081, 1'b1, 4'b0000, 4'b0000}, // R7 byte bis
        '{8'd8,  4'd10, 1'b0, 1'b0, 16'h8001, 16'h8000, 16'h0001, 1'b1, 4'b1001, 4'b1111}, // R8 xor both negative
        '{8'd8,  4'd10, 1'b0, 1'b1, 16'h5555, 16'h5555, 16'h0000, 1'b1, 4'b0010, 4'b1111}, // R8 xor zero
        '{8'd9,  4'd11, 1'b0, 1'b0, 16'h0000, 16'h8003, 16'hC001, 1'b1, 4'b0101, 4'b1111}, // R9 rra word
        '{8'd9,  4'd11, 1'b1, 1'b1, 16'h0000, 16'h1282, 16'h00C1, 1'b1, 4'b0100, 4'b1111}, // R9 rra byte
        '{8'd9,  4'd12, 1'b0, 1'b1, 16'h0000, 16'h0002, 16'h8001, 1'b1, 4'b0100, 4'b1111}, // R9 rrc carry into msb
        '{8'd9,  4'd12, 1'b1, 1'b0, 16'h0000, 16'h0001, 16'h0000, 1'b1, 4'b0011, 4'b1111}, // R9 rrc byte to zero
        '{8'd10, 4'd13, 1'b1, 1'b1, 16'hFFFF, 16'h12AB, 16'hAB12, 1'b1, 4'b0000, 4'b0000}, // R10 swap ignores byte
        '{8'd11, 4'd14, 1'b1, 1'b0, 16'h0000, 16'h0080, 16'hFF80, 1'b1, 4'b0101, 4'b1111}, // R11 sxt negative
        '{8'd11, 4'd14, 1'b0, 1'b1, 16'h0000, 16'hAB00, 16'h0000, 1'b1, 4'b0010, 4'b1111}, // R11 sxt zero
        '{8'd1,  4'd15, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 4'b0000, 4'b0000}  // R1 undefined code
    };

    logic        clk = 1'b0;
    logic [15:0] src_i, dst_i, res_o;
    logic [3:0]  op_i;
    logic        byte_i, c_i, we_o, v_o, n_o, z_o, c_o;
    logic        upd_v_o, upd_n_o, upd_z_o, upd_c_o;
    int          checks   = 0;
    int          failures = 0;
    logic        done     = 1'b0;

    always #4 clk = ~clk;

    alu16_flags i_alu16_flags (
        .src_i(src_i), .dst_i(dst_i), .op_i(op_i), .byte_i(byte_i), .c_i(c_i),
        .res_o(res_o), .we_o(we_o), .v_o(v_o), .n_o(n_o), .z_o(z_o), .c_o(c_o),
        .upd_v_o(upd_v_o), .upd_n_o(upd_n_o), .upd_z_o(upd_z_o), .upd_c_o(upd_c_o)
    );

    task automatic apply(input logic [3:0] op, input logic byt, input logic cin,
                         input logic [15:0] src, input logic [15:0] dst);
        @(negedge clk);
        op_i = op; byte_i = byt; c_i = cin; src_i = src; dst_i = dst;
        #2;
    endtask

    task automatic check(input string tag, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [24:0] outs();
        return {res_o, we_o, v_o, n_o, z_o, c_o, upd_v_o, upd_n_o, upd_z_o, upd_c_o};
    endfunction

    initial begin
        logic [24:0] first;
        op_i = 4'd15; byte_i = 1'b0; c_i = 1'b0; src_i = '0; dst_i = '0;

        // R1: idle code with zero inputs gives all-quiet outputs
        apply(4'd15, 1'b0, 1'b0, 16'h0000, 16'h0000);
        check("R1 idle", outs(), 25'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].byt, VECS[i].cin, VECS[i].src, VECS[i].dst);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), outs(),
                  {VECS[i].res, VECS[i].we, VECS[i].flg, VECS[i].msk});
        end

        // R2: ADD result unchanged by carry input
        apply(4'd0, 1'b0, 1'b0, 16'h0F0F, 16'h1111);
        first = outs();
        apply(4'd0, 1'b0, 1'b1, 16'h0F0F, 16'h1111);
        check("R2 add ignores carry", outs(), first);

        // R3: SUBC with carry set equals SUB
        apply(4'd3, 1'b0, 1'b1, 16'h0003, 16'h0005);
        check("R3 subc carry set", outs(), {16'h0002, 1'b1, 4'b0001, 4'b1111});

        // R2: ADDC carry in adds one
        apply(4'd1, 1'b0, 1'b1, 16'h0001, 16'h0001);
        check("R2 addc carry", outs(), {16'h0003, 1'b1, 4'b0000, 4'b1111});

        // R4: high byte of operands has no effect in byte mode
        apply(4'd0, 1'b1, 1'b0, 16'hAB01, 16'hCD02);
        check("R4 high byte ignored", outs(), {16'h0003, 1'b1, 4'b0000, 4'b1111});

        // R12: quiet op with carry input still reports no flag values
        apply(4'd9, 1'b0, 1'b1, 16'h8000, 16'h0000);
        check("R12 gated flags", outs(), {16'h8000, 1'b1, 4'b0000, 4'b0000});

        // R11: SXT ignores src
        apply(4'd14, 1'b0, 1'b0, 16'hFFFF, 16'h007F);
        check("R11 sxt positive", outs(), {16'h007F, 1'b1, 4'b0001, 4'b1111});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule